// File: doc/BRIEF.md
# Parallel Point-Multiplication Batch Dispatcher

This controller runs one batch of independent scalar-times-point jobs on a row of identical multiplication workers, and then passes their outputs to one shared merge-and-convert unit. A caller presents one scalar and one point operand per worker on wide load buses and pulses `start`. The controller copies every operand into its own registers. It then fires all workers together with a single-cycle start strobe and waits at a barrier until every worker has reported completion. Workers may finish in any order.

Each worker result is captured into a per-unit slot on that worker's own done pulse. Once the barrier clears, the full result array is handed to the converter with a one-cycle start. When the converter reports done, its merged value is stored and announced with a one-cycle valid pulse. The controller then returns to idle, ready for the next batch. The arithmetic inside the workers and the converter is outside this block.

Top module: `pm_batch_dispatch`

## Requirements
- R1: After reset, `wk_start`, `cv_start` and `out_valid` are all low, and the controller is idle.
- R2: A `start` sampled high while idle latches every operand lane (lane i of each load bus is bits i*W +: W). On the next clock edge, every bit of `wk_start` is high for exactly one cycle, with `wk_scalar`/`wk_point` carrying the latched lanes.
- R3: A `start` sampled while a batch is in flight is ignored: no worker is restarted, no operand changes, and no extra `out_valid` pulse appears.
- R4: `cv_start` is a one-cycle pulse. It is sampled high exactly two clock edges after the edge that samples the last outstanding worker `wk_done`, and never before every worker has reported done.
- R5: Worker completions are remembered individually, so any completion order, including simultaneous completion, clears the barrier exactly once.
- R6: Lane i of `cv_data` holds the value on lane i of `wk_result` at the edge where `wk_done[i]` was sampled high. Values on `wk_result` at other times are not used.
- R7: `out_valid` is high for exactly one cycle, sampled one edge after the edge that samples `cv_done`, with `out_data` equal to `cv_result` at that `cv_done` edge.
- R8: `out_data` keeps its value from one completed batch until the converter finishes the next one.
- R9: A `start` issued in the cycle after the `out_valid` pulse begins a new batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a batch (used only while idle) |
| ld_scalar | input | N_UNITS*SCALAR_W | Scalar operand per worker lane |
| ld_point | input | N_UNITS*POINT_W | Point operand per worker lane |
| wk_start | output | N_UNITS | One-cycle start strobe per worker |
| wk_scalar | output | N_UNITS*SCALAR_W | Latched scalar per worker |
| wk_point | output | N_UNITS*POINT_W | Latched point per worker |
| wk_done | input | N_UNITS | Completion pulse per worker |
| wk_result | input | N_UNITS*RES_W | Result per worker, valid with its done |
| cv_start | output | 1 | One-cycle start to the converter |
| cv_data | output | N_UNITS*RES_W | Captured worker results, lane per unit |
| cv_done | input | 1 | Converter completion pulse |
| cv_result | input | OUT_W | Converter result, valid with cv_done |
| out_valid | output | 1 | One-cycle announcement of a new result |
| out_data | output | OUT_W | Last merged result, held |

## Verification
Batches are run with three worker latency shapes: rising with lane number, falling with lane number, and all equal. These tell a barrier that truly waits for the slowest lane apart from one keyed to a fixed lane or confused by simultaneous completions. Worker results are driven as garbage outside their done pulse, so a controller that samples results at the wrong moment is exposed. One batch receives a second `start` mid-flight while the load buses are scrambled, which separates true operand latching and busy rejection from pass-through behaviour. A back-to-back batch confirms the return to idle.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_DISPATCH = 3'd1,
      ST_WAIT     = 3'd2,
      ST_CONVERT  = 3'd3,
      ST_CVWAIT   = 3'd4,
      ST_OUTPUT   = 3'd5
   } pmd_state_e;
endpackage

// File: rtl/pmd_seq.sv
module pmd_seq
   import pmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       all_done,
   input  logic       cv_done,
   output pmd_state_e state
);
   pmd_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:     if (start) nxt = ST_DISPATCH;
         ST_DISPATCH: nxt = ST_WAIT;
         ST_WAIT:     if (all_done) nxt = ST_CONVERT;
         ST_CONVERT:  nxt = ST_CVWAIT;
         ST_CVWAIT:   if (cv_done) nxt = ST_OUTPUT;
         ST_OUTPUT:   nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/pmd_done_track.sv
module pmd_done_track #(
   parameter int N_UNITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               arm,
   input  logic [N_UNITS-1:0] done_in,
   output logic               all_done
);
   logic [N_UNITS-1:0] sticky;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) sticky <= '0;
      else if (arm)        sticky <= sticky | done_in;
   end

   assign all_done = &sticky;
endmodule

// File: rtl/pmd_lane_bank.sv
module pmd_lane_bank #(
   parameter int N_UNITS = 8,
   parameter int LANE_W  = 16,
   localparam int BUS_W  = N_UNITS * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_UNITS-1:0] load,
   input  logic [BUS_W-1:0]   d,
   output logic [BUS_W-1:0]   q
);
   for (genvar i = 0; i < N_UNITS; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)       q[i*LANE_W +: LANE_W] <= '0;
         else if (load[i]) q[i*LANE_W +: LANE_W] <= d[i*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/pm_batch_dispatch.sv
module pm_batch_dispatch
   import pmd_pkg::*;
#(
   parameter int N_UNITS  = 8,
   parameter int SCALAR_W = 16,
   parameter int POINT_W  = 16,
   parameter int RES_W    = 16,
   parameter int OUT_W    = 16,
   localparam int SC_BUS  = N_UNITS * SCALAR_W,
   localparam int PT_BUS  = N_UNITS * POINT_W,
   localparam int RS_BUS  = N_UNITS * RES_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [SC_BUS-1:0]  ld_scalar,
   input  logic [PT_BUS-1:0]  ld_point,
   output logic [N_UNITS-1:0] wk_start,
   output logic [SC_BUS-1:0]  wk_scalar,
   output logic [PT_BUS-1:0]  wk_point,
   input  logic [N_UNITS-1:0] wk_done,
   input  logic [RS_BUS-1:0]  wk_result,
   output logic               cv_start,
   output logic [RS_BUS-1:0]  cv_data,
   input  logic               cv_done,
   input  logic [OUT_W-1:0]   cv_result,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_data
);
   if (N_UNITS < 1) begin : g_bad_units
      $error("pm_batch_dispatch: N_UNITS must be at least 1");
   end
   if (SCALAR_W < 1 || POINT_W < 1 || RES_W < 1 || OUT_W < 1) begin : g_bad_width
      $error("pm_batch_dispatch: all widths must be at least 1");
   end

   pmd_state_e         state;
   logic               all_done;
   logic               accept;
   logic               in_wait;
   logic [N_UNITS-1:0] capture;

   assign accept  = start && (state == ST_IDLE);
   assign in_wait = (state == ST_WAIT);
   assign capture = wk_done & {N_UNITS{in_wait}};

   pmd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .all_done (all_done),
      .cv_done  (cv_done),
      .state    (state)
   );

   pmd_done_track #(.N_UNITS(N_UNITS)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state == ST_DISPATCH),
      .arm      (in_wait),
      .done_in  (wk_done),
      .all_done (all_done)
   );

   pmd_lane_bank #(.N_UNITS(N_UNITS), .LANE_W(SCALAR_W)) u_scalars (
      .clk   (clk),
      .rst_n (rst_n),
      .load  ({N_UNITS{accept}}),
      .d     (ld_scalar),
      .q     (wk_scalar)
   );

   pmd_lane_bank #(.N_UNITS(N_UNITS), .LANE_W(POINT_W)) u_points (
      .clk   (clk),
      .rst_n (rst_n),
      .load  ({N_UNITS{accept}}),
      .d     (ld_point),
      .q     (wk_point)
   );

   pmd_lane_bank #(.N_UNITS(N_UNITS), .LANE_W(RES_W)) u_results (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (capture),
      .d     (wk_result),
      .q     (cv_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                              out_data <= '0;
      else if (state == ST_CVWAIT && cv_done)  out_data <= cv_result;
   end

   assign wk_start  = {N_UNITS{state == ST_DISPATCH}};
   assign cv_start  = (state == ST_CONVERT);
   assign out_valid = (state == ST_OUTPUT);
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
   parameter int N_UNITS = 8,
   parameter int OUT_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_UNITS-1:0] wk_start,
   input logic [N_UNITS-1:0] wk_done,
   input logic               cv_start,
   input logic               cv_done,
   input logic               out_valid,
   input logic [OUT_W-1:0]   out_data
);
   logic [N_UNITS-1:0] seen;
   logic               in_job;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen   <= '0;
         in_job <= 1'b0;
      end else begin
         seen <= (|wk_start) ? '0 : (seen | wk_done);
         if (|wk_start)     in_job <= 1'b1;
         else if (out_valid) in_job <= 1'b0;
      end
   end

   p_idle_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && !cv_start && (wk_start == '0));
   p_wk_pulse_r2:   assert property (@(posedge clk) disable iff (!rst_n) (|wk_start) |=> (wk_start == '0));
   p_wk_all_r2:     assert property (@(posedge clk) disable iff (!rst_n) (|wk_start) |-> (&wk_start));
   p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n) (|wk_start) |-> !in_job);
   p_ov_in_job_r3:  assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> in_job);
   p_cv_barrier_r4: assert property (@(posedge clk) disable iff (!rst_n) cv_start |-> (&seen));
   p_cv_pulse_r4:   assert property (@(posedge clk) disable iff (!rst_n) cv_start |=> !cv_start);
   p_ov_pulse_r7:   assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);
   p_out_hold_r8:   assert property (@(posedge clk) disable iff (!rst_n) !cv_done |=> $stable(out_data));
endmodule

bind pm_batch_dispatch pmd_checker #(.N_UNITS(N_UNITS), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wk_start  (wk_start),
   .wk_done   (wk_done),
   .cv_start  (cv_start),
   .cv_done   (cv_done),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/tb_pm_batch_dispatch.sv
module tb_pm_batch_dispatch;
   localparam int N = 8;
   localparam int W = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [N*W-1:0] ld_scalar = '0, ld_point = '0;
   logic [N-1:0]   wk_start;
   logic [N*W-1:0] wk_scalar, wk_point, cv_data;
   logic [N-1:0]   wk_done = '0;
   logic [N*W-1:0] wk_result = '0;
   logic           cv_start, cv_done = 1'b0, out_valid;
   logic [W-1:0]   cv_result = '0, out_data;

   pm_batch_dispatch #(.N_UNITS(N), .SCALAR_W(W), .POINT_W(W), .RES_W(W), .OUT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ld_scalar(ld_scalar), .ld_point(ld_point),
      .wk_start(wk_start), .wk_scalar(wk_scalar), .wk_point(wk_point), .wk_done(wk_done),
      .wk_result(wk_result), .cv_start(cv_start), .cv_data(cv_data), .cv_done(cv_done),
      .cv_result(cv_result), .out_valid(out_valid), .out_data(out_data));

   always #5 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0, cur_job = 0, start_edge = -10;
   int last_done_edge = 0, cvdone_edge = -10, out_seen = 0, jobs_started = 0;
   int startcnt [N];
   int wcnt [N];
   logic [W-1:0] wres [N];
   logic [W-1:0] exp_sc [N], exp_pt [N], exp_res [N];
   logic [W-1:0] exp_q [$];
   logic [W-1:0] cv_acc;
   int ccnt = 0;
   logic ov_prev = 1'b0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [W-1:0] unit_res(logic [W-1:0] s, logic [W-1:0] p, int i);
      logic [2*W-1:0] prod;
      prod = s * p;
      return prod[W-1:0] + W'(i * 7);
   endfunction

   function automatic int wlat(int i, int j);
      case (j % 3)
         0:       return 2 + i * 3;
         1:       return 2 + (N - 1 - i) * 2;
         default: return 5;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // worker stubs (one process for all lanes)
   initial for (int i = 0; i < N; i++) begin startcnt[i] = 0; wcnt[i] = 0; wres[i] = '0; end
   always @(posedge clk) begin
      int mx;
      mx = last_done_edge;
      for (int i = 0; i < N; i++) begin
         wk_done[i] <= 1'b0;
         wk_result[i*W +: W] <= 16'hDEAD;
         if (wk_start[i]) begin
            startcnt[i]++;
            if (i == 0) mx = 0;
            chk(cyc == start_edge + 1, "R2/R3 dispatch edge", cyc, start_edge + 1);
            chk(wk_scalar[i*W +: W] == exp_sc[i], "R2 scalar lane", wk_scalar[i*W +: W], exp_sc[i]);
            chk(wk_point[i*W +: W] == exp_pt[i], "R2 point lane", wk_point[i*W +: W], exp_pt[i]);
            wres[i] = unit_res(wk_scalar[i*W +: W], wk_point[i*W +: W], i);
            wcnt[i] = wlat(i, cur_job);
         end else if (wcnt[i] != 0) begin
            wcnt[i]--;
            if (wcnt[i] == 0) begin
               wk_done[i] <= 1'b1;
               wk_result[i*W +: W] <= wres[i];
               if (cyc + 1 > mx) mx = cyc + 1;
            end
         end
      end
      last_done_edge <= mx;
   end

   // converter stub
   always @(posedge clk) begin
      cv_done   <= 1'b0;
      cv_result <= 16'hBEEF;
      if (cv_start) begin
         chk(cyc == last_done_edge + 2, "R4/R5 convert start edge", cyc, last_done_edge + 2);
         cv_acc = '0;
         for (int i = 0; i < N; i++) begin
            chk(cv_data[i*W +: W] == exp_res[i], "R6 captured lane", cv_data[i*W +: W], exp_res[i]);
            cv_acc = cv_acc + cv_data[i*W +: W];
         end
         cv_acc = cv_acc ^ 16'hA5C3;
         ccnt = 2 + cur_job % 4;
      end else if (ccnt != 0) begin
         ccnt--;
         if (ccnt == 0) begin
            cv_done     <= 1'b1;
            cv_result   <= cv_acc;
            cvdone_edge <= cyc + 1;
         end
      end
   end

   always @(posedge clk)
      if (out_valid) chk(cyc == cvdone_edge + 1, "R7 valid edge", cyc, cvdone_edge + 1);

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            chk(!ov_prev, "R7 single-cycle valid", 1, 0);
            if (exp_q.size() == 0) chk(0, "R3 unexpected output", out_data, 0);
            else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(out_data == e, "R7 merged result", out_data, e);
            end
            out_seen++;
         end
         ov_prev = out_valid;
      end
   end

   task automatic run_job(input int j, input bit poke, input bit hold_check);
      int prev;
      logic [W-1:0] sum;
      sum = '0;
      for (int i = 0; i < N; i++) begin
         exp_sc[i]  = W'(j * 1237 + i * 311 + 5);
         exp_pt[i]  = W'(j * 97 + i * 41 + 3);
         exp_res[i] = unit_res(exp_sc[i], exp_pt[i], i);
         sum = sum + exp_res[i];
         ld_scalar[i*W +: W] = exp_sc[i];
         ld_point[i*W +: W]  = exp_pt[i];
      end
      prev = out_seen;
      @(negedge clk);
      cur_job = j;
      start_edge = cyc;
      start = 1'b1;
      exp_q.push_back(sum ^ 16'hA5C3);
      jobs_started++;
      @(negedge clk);
      start = 1'b0;
      ld_scalar = ~ld_scalar;
      ld_point  = ~ld_point;
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1;   // R3: must be ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (out_seen == prev) @(negedge clk);
      for (int i = 0; i < N; i++)
         chk(startcnt[i] == jobs_started, "R3 worker start count", startcnt[i], jobs_started);
      if (hold_check) begin
         repeat (6) @(negedge clk);
         chk(out_data == (sum ^ 16'hA5C3), "R8 result held", out_data, sum ^ 16'hA5C3);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(wk_start == '0, "R1 wk_start after reset", wk_start, 0);
      chk(!cv_start, "R1 cv_start after reset", cv_start, 0);
      chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(wk_start == '0 && !out_valid, "R1 idle without start", {wk_start, out_valid}, 0);
      run_job(0, 0, 1);   // rising latencies
      run_job(1, 0, 1);   // falling latencies
      run_job(2, 0, 1);   // equal latencies, R5 simultaneous completion
      run_job(3, 1, 1);   // R3 start while busy
      run_job(4, 0, 0);   // R9 back-to-back follows
      run_job(5, 0, 1);
      chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule